// File: doc/BRIEF.md
# Burst Amplitude PWM with Programmable Ceiling

This block drives the amplitude-control pin of an external frequency synthesizer. Its output is an 8-bit pulse-width modulated signal. In this system a higher duty means a quieter output. The top duty value, where the synthesizer falls silent, is set by software through a ceiling input. Lower duty values raise the output level, and a duty of zero gives full amplitude.

A transmission burst is a sequence of symbols. A symbol-start pulse marks the start of each symbol and carries two flags, one for the first symbol and one for the last. A millisecond pulse advances the position inside the current symbol. The amplitude follows a smoothed twenty-step rise over the first 20 ms of the first symbol. It follows the mirrored fall over the final 20 ms of the last symbol, and is constant in between. Between bursts the output rests at the ceiling.

A new duty value only takes effect at the boundary of a PWM period. This avoids runt pulses on the pin and the filter behind it.

Top module: `amp_ramp_pwm`

## Requirements
- R1: The PWM period is 256 ticks. In each period `pwm_o` is high for exactly the first D ticks, where D is the duty latched for that period. D=0 means never high, and D=255 means high for 255 of 256 ticks.
- R2: The duty is D = C - floor((F*C + 127)/255), where C is the ceiling and F is the amplitude fraction (0..255). F=255 gives D=0, F=0 gives D=C, and D never exceeds C.
- R3: After reset, with no symbol started, the duty equals the ceiling.
- R4: In the first symbol, millisecond index k (0..19) uses F = T[k]. From index 20 onward F=255. The table T is 0,3,5,8,13,18,26,38,51,102,153,204,217,230,237,242,247,250,252,255.
- R5: In a symbol flagged neither first nor last, F=255 throughout.
- R6: In the last symbol, index m below SYM_MS-20 uses F=255. Index m at or above SYM_MS-20 uses F = T[SYM_MS-1-m], which reaches T[0]=0 at the final millisecond.
- R7: A millisecond pulse at index SYM_MS-1 of the last symbol ends the burst, and the duty returns to the ceiling. Millisecond pulses outside a burst have no effect.
- R8: The latched duty, including the effect of a ceiling change, changes only at a PWM period boundary.
- R9: A symbol-start pulse sets the millisecond index to 0 and captures both flags. It takes priority over a millisecond pulse in the same cycle.
- R10: In a symbol that is not the last, the millisecond index stops at SYM_MS-1 and does not wrap, however many extra pulses arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_start_i | input | 1 | One-cycle pulse at the start of each symbol |
| sym_first_i | input | 1 | Symbol is the first of the burst (sampled with sym_start_i) |
| sym_last_i | input | 1 | Symbol is the last of the burst (sampled with sym_start_i) |
| ms_tick_i | input | 1 | One-cycle pulse per elapsed millisecond |
| ceiling_i | input | 8 | Software ceiling, the silent duty value |
| pwm_o | output | 1 | PWM amplitude-control output |

## Verification
The bench builds the block with SYM_MS=24 and CE_DIV=1. With these values the rise, the hold, the four constant milliseconds before the fall, and the full fall all fit in one short run, and each millisecond step spans several PWM periods. Over each step the high time is counted across one full 256-cycle window and compared with the table value scaled by the ceiling. Ceilings of 0, 100, 153, 200 and 255 exercise the end points of the scaling. A coincident symbol-start and millisecond pulse, and surplus millisecond pulses, cover the index priority and saturation.

// File: rtl/amp_pwm_pkg.sv
package amp_pwm_pkg;

    localparam int unsigned LVL_W      = 8;
    localparam int unsigned RAMP_STEPS = 20;
    localparam int unsigned STEP_W     = $clog2(RAMP_STEPS);
    localparam int unsigned LVL_FULL   = (1 << LVL_W) - 1;

    typedef logic [LVL_W-1:0]  level_t;
    typedef logic [STEP_W-1:0] step_t;

    typedef enum logic {
        BURST_IDLE   = 1'b0,
        BURST_ACTIVE = 1'b1
    } burst_e;

    typedef struct packed {
        logic is_first;
        logic is_last;
    } sym_flags_t;

    // Smoothed edge shape, fraction of full amplitude scaled to 255.
    function automatic level_t edge_shape(input step_t k);
        level_t v;
        case (k)
            5'd0:    v = 8'd0;
            5'd1:    v = 8'd3;
            5'd2:    v = 8'd5;
            5'd3:    v = 8'd8;
            5'd4:    v = 8'd13;
            5'd5:    v = 8'd18;
            5'd6:    v = 8'd26;
            5'd7:    v = 8'd38;
            5'd8:    v = 8'd51;
            5'd9:    v = 8'd102;
            5'd10:   v = 8'd153;
            5'd11:   v = 8'd204;
            5'd12:   v = 8'd217;
            5'd13:   v = 8'd230;
            5'd14:   v = 8'd237;
            5'd15:   v = 8'd242;
            5'd16:   v = 8'd247;
            5'd17:   v = 8'd250;
            5'd18:   v = 8'd252;
            default: v = 8'd255;
        endcase
        return v;
    endfunction

    // Inverted-sense mapping: full amplitude -> 0, silence -> ceiling.
    function automatic level_t amp_to_duty(input level_t ceil, input level_t frac);
        logic [2*LVL_W:0] prod;
        logic [2*LVL_W:0] quot;
        prod = (2*LVL_W+1)'(ceil) * (2*LVL_W+1)'(frac) + (2*LVL_W+1)'(LVL_FULL / 2);
        quot = prod / (2*LVL_W+1)'(LVL_FULL);
        return ceil - level_t'(quot);
    endfunction

    function automatic level_t lvl_min(input level_t a, input level_t b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/amp_burst_seq.sv
module amp_burst_seq
    import amp_pwm_pkg::*;
#(
    parameter int unsigned SYM_MS = 160
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   sym_start_i,
    input  logic   sym_first_i,
    input  logic   sym_last_i,
    input  logic   ms_tick_i,
    output level_t frac_o
);

    localparam int unsigned MS_W = $clog2(SYM_MS);
    localparam logic [MS_W-1:0] IDX_LAST  = MS_W'(SYM_MS - 1);
    localparam logic [MS_W-1:0] IDX_RISE  = MS_W'(RAMP_STEPS);
    localparam logic [MS_W-1:0] IDX_FALL  = MS_W'(SYM_MS - RAMP_STEPS);

    burst_e          state_q;
    sym_flags_t      flags_q;
    logic [MS_W-1:0] ms_idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= BURST_IDLE;
            flags_q  <= '0;
            ms_idx_q <= '0;
        end else if (sym_start_i) begin
            state_q          <= BURST_ACTIVE;
            flags_q.is_first <= sym_first_i;
            flags_q.is_last  <= sym_last_i;
            ms_idx_q         <= '0;
        end else if (ms_tick_i && state_q == BURST_ACTIVE) begin
            if (ms_idx_q == IDX_LAST) begin
                if (flags_q.is_last) begin
                    state_q  <= BURST_IDLE;
                    ms_idx_q <= '0;
                end
            end else begin
                ms_idx_q <= ms_idx_q + 1'b1;
            end
        end
    end

    logic [MS_W-1:0] fall_pos;
    level_t          rise_lvl;
    level_t          fall_lvl;

    always_comb begin
        fall_pos = IDX_LAST - ms_idx_q;
        rise_lvl = level_t'(LVL_FULL);
        fall_lvl = level_t'(LVL_FULL);
        if (flags_q.is_first && ms_idx_q < IDX_RISE)
            rise_lvl = edge_shape(step_t'(ms_idx_q));
        if (flags_q.is_last && ms_idx_q >= IDX_FALL)
            fall_lvl = edge_shape(step_t'(fall_pos));
        if (state_q == BURST_ACTIVE)
            frac_o = lvl_min(rise_lvl, fall_lvl);
        else
            frac_o = '0;
    end

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        ms_idx_q <= IDX_LAST); // R10

    AST_START_RESETS_IDX: assert property (@(posedge clk) disable iff (rst)
        sym_start_i |=> (ms_idx_q == '0) && (state_q == BURST_ACTIVE)); // R9

    AST_END_ONLY_AT_TAIL: assert property (@(posedge clk) disable iff (rst)
        (state_q == BURST_IDLE && $past(state_q) == BURST_ACTIVE && !$past(rst))
            |-> ($past(flags_q.is_last) && $past(ms_idx_q) == IDX_LAST)); // R7

    AST_RISE_MONOTONE: assert property (@(posedge clk) disable iff (rst)
        (state_q == BURST_ACTIVE && flags_q.is_first && !flags_q.is_last &&
         !$past(sym_start_i) && $past(state_q) == BURST_ACTIVE && !$past(rst))
            |-> frac_o >= $past(frac_o)); // R4

    AST_FALL_MONOTONE: assert property (@(posedge clk) disable iff (rst)
        (state_q == BURST_ACTIVE && flags_q.is_last && !flags_q.is_first &&
         !$past(sym_start_i) && $past(state_q) == BURST_ACTIVE && !$past(rst))
            |-> frac_o <= $past(frac_o)); // R6

endmodule

// File: rtl/amp_duty_scale.sv
module amp_duty_scale
    import amp_pwm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  level_t ceil_i,
    input  level_t frac_i,
    output level_t duty_o
);

    level_t duty_q;

    always_ff @(posedge clk) begin
        if (rst) duty_q <= level_t'(LVL_FULL);
        else     duty_q <= amp_to_duty(ceil_i, frac_i);
    end

    assign duty_o = duty_q;

    AST_DUTY_UNDER_CEIL: assert property (@(posedge clk) disable iff (rst)
        !rst |=> duty_q <= $past(ceil_i)); // R2

    AST_FULL_AMP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (frac_i == level_t'(LVL_FULL)) |=> duty_q == '0); // R2

endmodule

// File: rtl/amp_pwm_core.sv
module amp_pwm_core
    import amp_pwm_pkg::*;
#(
    parameter int unsigned CE_DIV = 1
) (
    input  logic   clk,
    input  logic   rst,
    input  level_t duty_i,
    output logic   pwm_o
);

    logic tick;

    generate
        if (CE_DIV <= 1) begin : g_ce_every
            assign tick = 1'b1;
        end else begin : g_ce_div
            localparam int unsigned DIV_W = $clog2(CE_DIV);
            logic [DIV_W-1:0] div_q;
            always_ff @(posedge clk) begin
                if (rst)                             div_q <= '0;
                else if (div_q == DIV_W'(CE_DIV-1))  div_q <= '0;
                else                                 div_q <= div_q + 1'b1;
            end
            assign tick = (div_q == DIV_W'(CE_DIV-1));
        end
    endgenerate

    level_t cnt_q;
    level_t duty_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            duty_q <= level_t'(LVL_FULL);
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == level_t'(LVL_FULL))
                duty_q <= duty_i;
        end
    end

    assign pwm_o = (cnt_q < duty_q);

    AST_LATCH_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0) |-> $stable(duty_q)); // R8

    AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (rst)
        (duty_q == '0) |-> !pwm_o); // R1

    AST_HIGH_BEFORE_LOW: assert property (@(posedge clk) disable iff (rst)
        ($fell(pwm_o) && cnt_q != '0) |-> (cnt_q == duty_q)); // R1

endmodule

// File: rtl/amp_ramp_pwm.sv
module amp_ramp_pwm
    import amp_pwm_pkg::*;
#(
    parameter int unsigned SYM_MS = 160,
    parameter int unsigned CE_DIV = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sym_start_i,
    input  logic       sym_first_i,
    input  logic       sym_last_i,
    input  logic       ms_tick_i,
    input  logic [7:0] ceiling_i,
    output logic       pwm_o
);

    level_t frac;
    level_t duty;

    amp_burst_seq #(.SYM_MS(SYM_MS)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .sym_start_i (sym_start_i),
        .sym_first_i (sym_first_i),
        .sym_last_i  (sym_last_i),
        .ms_tick_i   (ms_tick_i),
        .frac_o      (frac)
    );

    amp_duty_scale u_scale (
        .clk    (clk),
        .rst    (rst),
        .ceil_i (ceiling_i),
        .frac_i (frac),
        .duty_o (duty)
    );

    amp_pwm_core #(.CE_DIV(CE_DIV)) u_pwm (
        .clk    (clk),
        .rst    (rst),
        .duty_i (duty),
        .pwm_o  (pwm_o)
    );

endmodule

// File: tb/sim_amp_ramp_pwm.sv
module sim_amp_ramp_pwm;

    localparam int CLK_PERIOD = 10;
    localparam int SYM_MS     = 24;
    localparam int FALL_AT    = SYM_MS - 20;

    typedef struct {
        int    exp;
        string tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sym_start = 1'b0;
    logic       sym_first = 1'b0;
    logic       sym_last  = 1'b0;
    logic       ms_tick   = 1'b0;
    logic [7:0] ceiling   = 8'd200;
    logic       pwm;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    finished = 1'b0;
    item_t sb_q[$];
    event  meas_go;

    int shape [20] = '{0,3,5,8,13,18,26,38,51,102,153,204,217,230,237,242,247,250,252,255};

    always #(CLK_PERIOD/2) clk = ~clk;

    amp_ramp_pwm #(.SYM_MS(SYM_MS), .CE_DIV(1)) u0 (
        .clk         (clk),
        .rst         (rst),
        .sym_start_i (sym_start),
        .sym_first_i (sym_first),
        .sym_last_i  (sym_last),
        .ms_tick_i   (ms_tick),
        .ceiling_i   (ceiling),
        .pwm_o       (pwm)
    );

    function automatic int duty_of(int f, int c);
        return c - (f * c + 127) / 255;
    endfunction

    // Monitor: counts high cycles over one full period, pops and compares.
    initial begin
        forever begin
            int    highs;
            item_t it;
            @(meas_go);
            highs = 0;
            for (int i = 0; i < 256; i++) begin
                @(negedge clk);
                highs += int'(pwm);
            end
            it = sb_q.pop_front();
            n_checks++;
            if (highs != it.exp) begin
                n_fail++;
                $display("FAIL %s: high ticks actual=%0d expected=%0d", it.tag, highs, it.exp);
            end
        end
    end

    task automatic expect_now(int exp, string tag);
        item_t it;
        repeat (600) @(negedge clk);
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
        -> meas_go;
        repeat (400) @(negedge clk);
    endtask

    task automatic ms_step(int exp, string tag);
        ms_tick = 1'b1;
        @(negedge clk);
        ms_tick = 1'b0;
        expect_now(exp, tag);
    endtask

    task automatic sym_begin(bit first, bit last, bit with_tick, int exp, string tag);
        sym_start = 1'b1;
        sym_first = first;
        sym_last  = last;
        ms_tick   = with_tick;
        @(negedge clk);
        sym_start = 1'b0;
        sym_first = 1'b0;
        sym_last  = 1'b0;
        ms_tick   = 1'b0;
        expect_now(exp, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R3: idle after reset rests at ceiling
        expect_now(200, "R3 idle after reset");

        // R4: first symbol rise at ceiling 200
        sym_begin(1'b1, 1'b0, 1'b0, duty_of(shape[0], 200), "R4 rise ms0");
        for (int k = 1; k < SYM_MS; k++)
            ms_step(duty_of(k < 20 ? shape[k] : 255, 200), $sformatf("R4 rise ms%0d", k));

        // R10: surplus pulses do not wrap the index back into the rise
        for (int k = 0; k < 6; k++)
            ms_step(0, $sformatf("R10 surplus pulse %0d", k));

        // R5: middle symbol holds full amplitude
        sym_begin(1'b0, 1'b0, 1'b0, 0, "R5 middle ms0");
        for (int k = 1; k < SYM_MS; k++)
            ms_step(0, $sformatf("R5 middle ms%0d", k));

        // R6: last symbol at ceiling 153
        @(negedge clk);
        ceiling = 8'd153;
        sym_begin(1'b0, 1'b1, 1'b0, 0, "R6 last ms0");
        for (int m = 1; m < SYM_MS; m++)
            ms_step(m < FALL_AT ? 0 : duty_of(shape[SYM_MS-1-m], 153), $sformatf("R6 last ms%0d", m));

        // R7: final pulse ends burst; pulses when idle are ignored
        ms_step(153, "R7 burst end");
        ms_step(153, "R7 idle pulse ignored");

        // R8 / R1: ceiling change in idle takes effect after a boundary
        @(negedge clk);
        ceiling = 8'd255;
        expect_now(255, "R8 R1 ceiling 255");
        @(negedge clk);
        ceiling = 8'd0;
        expect_now(0, "R2 R1 ceiling 0");

        // R9: symbol start wins over a coincident millisecond pulse
        @(negedge clk);
        ceiling = 8'd100;
        sym_begin(1'b1, 1'b1, 1'b1, duty_of(shape[0], 100), "R9 start priority");
        for (int k = 1; k < 4; k++)
            ms_step(duty_of(shape[k], 100), $sformatf("R9 R2 rise ms%0d", k));

        repeat (300) @(negedge clk);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule